// File: doc/BRIEF.md
# Width-Doubling Dual-Clock FIFO

This block moves a stream of 128-bit words from a write clock domain into an unrelated read clock domain. On the read side it delivers 256-bit words. Every read word is built from two consecutive write words. It is meant for bursty sample capture, where the writer runs in short fast bursts and the reader drains at a steady pace. In such a stream no data may be dropped or reordered, as long as the long-run write rate does not exceed what the reader removes.

The storage holds 2048 write words, which is 1024 read words. Each domain keeps its own binary pointer. It passes a Gray-coded copy of that pointer to the other domain through a two-flop synchronizer. The write side compares the read pointer at write-word granularity by doubling it. The read side counts only complete pairs of write words. Each side reports its own fill level in its own word size. Each side also keeps a sticky error flag for a refused access.

Top module: `awf_async_widen`

## Requirements
- R1: A read returns the oldest unread pair of write words. The earlier word is in bits 127:0 and the later word is in bits 255:128. The word appears on `rd_data_o` after the read clock edge that accepts the read.
- R2: `rd_empty_o` stays high while fewer than two unread write words have been committed. A single unpaired write word never makes the FIFO non-empty.
- R3: `wr_full_o` goes high when 2048 write words are held. A write while full is ignored: the stored data and `wr_level_o` do not change, and `wr_overflow_o` sets and stays set until reset.
- R4: A read while empty is ignored: `rd_data_o` and `rd_level_o` do not change, and `rd_underflow_o` sets and stays set until reset.
- R5: `wr_level_o` counts held 128-bit words, from 0 to 2048. `rd_level_o` counts complete 256-bit words, from 0 to 1024. Each level follows the other domain's pointer within a few cycles.
- R6: While the resets are asserted, the pointers and both flags are cleared. After release, `rd_empty_o`=1, `wr_full_o`=0, both levels are 0 and both flags are 0. Each domain has its own reset, released on its own.
- R7: When write bursts and reads run together on unrelated clocks, every written word comes out once and in order. The pointer copies that cross domains change at most one bit per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write clock |
| wr_rst_ni | input | 1 | Write-domain asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | 128 | Write word |
| wr_full_o | output | 1 | No room for a write word |
| wr_level_o | output | 12 | Held words, in 128-bit units |
| wr_overflow_o | output | 1 | Sticky: a write was refused |
| rd_clk_i | input | 1 | Read clock |
| rd_rst_ni | input | 1 | Read-domain asynchronous reset, active low |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | 256 | Read word, registered |
| rd_empty_o | output | 1 | No complete read word available |
| rd_level_o | output | 11 | Complete words held, in 256-bit units |
| rd_underflow_o | output | 1 | Sticky: a read was refused |

## Verification
Two events can fall in the same read cycle. One is the arrival of a synchronized write pointer that completes a pair. The other is a read request taken against the empty flag computed before that arrival. The burst scenario provokes this by letting the reader decide on every read cycle from the live `rd_empty_o` while the writer is still mid-burst. Each result is judged against a model queue of the written words. A read that consumes a pair too early shows up as a half-stale word or a shifted sequence. Likewise, a write refused at the full boundary is judged by draining all 1024 words and confirming the dropped word never appears.

// File: rtl/awf_pkg.sv
package awf_pkg;
  localparam int unsigned WR_W_DEF     = 128;
  localparam int unsigned WR_DEPTH_DEF = 2048;
endpackage

// File: rtl/awf_gray_sync.sv
module awf_gray_sync #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    bin_o[W-1] = s2_q[W-1];
    for (int i = W - 2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ s2_q[i];
  end
endmodule

// File: rtl/awf_wr_ctrl.sv
module awf_wr_ctrl #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned PW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [PW-2:0] rptr_bin_i,
  output logic          we_o,
  output logic [PW-2:0] waddr_o,
  output logic [PW-1:0] wgray_o,
  output logic          full_o,
  output logic [PW-1:0] level_o,
  output logic          overflow_o
);
  logic [PW-1:0] wptr_q, wptr_d;

  assign level_o = wptr_q - {rptr_bin_i, 1'b0};
  assign full_o  = (level_o == PW'(DEPTH));
  assign we_o    = en_i && !full_o;
  assign waddr_o = wptr_q[PW-2:0];
  assign wptr_d  = wptr_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q     <= '0;
      wgray_o    <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (we_o) begin
        wptr_q  <= wptr_d;
        wgray_o <= wptr_d ^ (wptr_d >> 1);
      end
      if (en_i && full_o) overflow_o <= 1'b1;
    end
  end

  a_r3_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && full_o) |=> $stable(wptr_q));
  a_r3_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  a_r5_wr_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= PW'(DEPTH));
  a_r7_wgray_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wgray_o ^ $past(wgray_o)) <= 1);
endmodule

// File: rtl/awf_rd_ctrl.sv
module awf_rd_ctrl #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned PW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [PW:0]   wptr_bin_i,
  output logic          re_o,
  output logic [PW-2:0] raddr_o,
  output logic [PW-2:0] rptr_bin_o,
  output logic [PW-1:0] rgray_o,
  output logic          empty_o,
  output logic [PW-1:0] level_o,
  output logic          underflow_o
);
  logic [PW-1:0] rptr_q, rptr_d;

  // only whole pairs of write words count
  assign level_o    = wptr_bin_i[PW:1] - rptr_q;
  assign empty_o    = (level_o == '0);
  assign re_o       = en_i && !empty_o;
  assign raddr_o    = rptr_q[PW-2:0];
  assign rptr_bin_o = rptr_q[PW-2:0];
  assign rptr_d     = rptr_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q      <= '0;
      rgray_o     <= '0;
      underflow_o <= 1'b0;
    end else begin
      if (re_o) begin
        rptr_q  <= rptr_d;
        rgray_o <= rptr_d ^ (rptr_d >> 1);
      end
      if (en_i && empty_o) underflow_o <= 1'b1;
    end
  end

  a_r4_empty_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && empty_o) |=> $stable(rptr_q));
  a_r4_unf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);
  a_r5_rd_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= PW'(DEPTH));
  a_r7_rgray_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rgray_o ^ $past(rgray_o)) <= 1);
endmodule

// File: rtl/awf_mem.sv
module awf_mem #(
  parameter int unsigned DW = 128,
  parameter int unsigned AW = 10
) (
  input  logic          wr_clk_i,
  input  logic          we_i,
  input  logic [AW:0]   waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_clk_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [2*DW-1:0] rdata_o
);
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [DW-1:0] bank [2**AW];
    logic [DW-1:0] q;

    // even write words land in the low half, odd ones in the high half
    always_ff @(posedge wr_clk_i)
      if (we_i && (waddr_i[0] == 1'(h))) bank[waddr_i[AW:1]] <= wdata_i;

    always_ff @(posedge rd_clk_i)
      if (re_i) q <= bank[raddr_i];

    assign rdata_o[h*DW +: DW] = q;
  end
endmodule

// File: rtl/awf_async_widen.sv
module awf_async_widen #(
  parameter int unsigned WR_W     = awf_pkg::WR_W_DEF,
  parameter int unsigned WR_DEPTH = awf_pkg::WR_DEPTH_DEF,
  localparam int unsigned RD_W     = 2 * WR_W,
  localparam int unsigned RD_DEPTH = WR_DEPTH / 2,
  localparam int unsigned WPW      = $clog2(WR_DEPTH) + 1,
  localparam int unsigned RPW      = $clog2(RD_DEPTH) + 1
) (
  input  logic            wr_clk_i,
  input  logic            wr_rst_ni,
  input  logic            wr_en_i,
  input  logic [WR_W-1:0] wr_data_i,
  output logic            wr_full_o,
  output logic [WPW-1:0]  wr_level_o,
  output logic            wr_overflow_o,
  input  logic            rd_clk_i,
  input  logic            rd_rst_ni,
  input  logic            rd_en_i,
  output logic [RD_W-1:0] rd_data_o,
  output logic            rd_empty_o,
  output logic [RPW-1:0]  rd_level_o,
  output logic            rd_underflow_o
);
  logic           we, re;
  logic [WPW-2:0] waddr;
  logic [RPW-2:0] raddr;
  logic [WPW-1:0] wgray, wbin_rd;
  logic [RPW-1:0] rgray, rbin_wr;
  logic [RPW-2:0] rptr_unused;

  awf_wr_ctrl #(.DEPTH(WR_DEPTH)) u_wr (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_ni), .en_i(wr_en_i),
    .rptr_bin_i(rbin_wr), .we_o(we), .waddr_o(waddr), .wgray_o(wgray),
    .full_o(wr_full_o), .level_o(wr_level_o), .overflow_o(wr_overflow_o));

  awf_rd_ctrl #(.DEPTH(RD_DEPTH)) u_rd (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_ni), .en_i(rd_en_i),
    .wptr_bin_i(wbin_rd), .re_o(re), .raddr_o(raddr), .rptr_bin_o(rptr_unused),
    .rgray_o(rgray), .empty_o(rd_empty_o), .level_o(rd_level_o),
    .underflow_o(rd_underflow_o));

  awf_gray_sync #(.W(WPW)) u_w2r (
    .clk_i(rd_clk_i), .rst_ni(rd_rst_ni), .gray_i(wgray), .bin_o(wbin_rd));

  awf_gray_sync #(.W(RPW)) u_r2w (
    .clk_i(wr_clk_i), .rst_ni(wr_rst_ni), .gray_i(rgray), .bin_o(rbin_wr));

  awf_mem #(.DW(WR_W), .AW(RPW - 1)) u_mem (
    .wr_clk_i(wr_clk_i), .we_i(we), .waddr_i(waddr), .wdata_i(wr_data_i),
    .rd_clk_i(rd_clk_i), .re_i(re), .raddr_i(raddr), .rdata_o(rd_data_o));
endmodule

// File: tb/tb_awf_async_widen.sv
module tb_awf_async_widen;
  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst_n = 0, rd_rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [127:0] wr_data = '0;
  logic [255:0] rd_data;
  logic wr_full, wr_ovf, rd_empty, rd_unf;
  logic [11:0] wr_level;
  logic [10:0] rd_level;
  int n_chk = 0, n_bad = 0;
  int wr_idx = 0, rd_idx = 0;
  bit done = 0;

  always #10 wr_clk = ~wr_clk;
  always #17 rd_clk = ~rd_clk;

  awf_async_widen dut (
    .wr_clk_i(wr_clk), .wr_rst_ni(wr_rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_full_o(wr_full), .wr_level_o(wr_level), .wr_overflow_o(wr_ovf),
    .rd_clk_i(rd_clk), .rd_rst_ni(rd_rst_n), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .rd_empty_o(rd_empty), .rd_level_o(rd_level), .rd_underflow_o(rd_unf));

  function automatic logic [127:0] mkw(int k);
    return {k[31:0], ~k[31:0], k[31:0] * 3, k[31:0] + 32'h1234_0007};
  endfunction

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd_wait(int n);
    repeat (n) @(negedge rd_clk);
  endtask

  task automatic wr_wait(int n);
    repeat (n) @(negedge wr_clk);
  endtask

  task automatic push(int k);
    @(negedge wr_clk);
    wr_en = 1; wr_data = mkw(k);
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic pop_check(string req);
    @(negedge rd_clk);
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
    chk(req, rd_data, {mkw(rd_idx + 1), mkw(rd_idx)});
    rd_idx += 2;
  endtask

  task automatic t_reset;
    rd_wait(1);
    chk("R6 empty", 256'(rd_empty), 256'd1);
    chk("R6 rd_level", 256'(rd_level), 256'd0);
    chk("R6 unf", 256'(rd_unf), 256'd0);
    chk("R6 full", 256'(wr_full), 256'd0);
    chk("R6 wr_level", 256'(wr_level), 256'd0);
    chk("R6 ovf", 256'(wr_ovf), 256'd0);
  endtask

  task automatic t_pairing;
    push(wr_idx); wr_idx++;
    rd_wait(6);
    chk("R2 single word stays empty", 256'(rd_empty), 256'd1);
    chk("R5 rd_level half word", 256'(rd_level), 256'd0);
    chk("R5 wr_level one", 256'(wr_level), 256'd1);
    push(wr_idx); wr_idx++;
    rd_wait(6);
    chk("R2 pair not empty", 256'(rd_empty), 256'd0);
    chk("R5 rd_level one", 256'(rd_level), 256'd1);
    pop_check("R1 low/high order");
    chk("R2 empty after pop", 256'(rd_empty), 256'd1);
  endtask

  task automatic t_underflow;
    logic [255:0] prev;
    prev = rd_data;
    @(negedge rd_clk); rd_en = 1;
    @(negedge rd_clk); rd_en = 0;
    chk("R4 data held", rd_data, prev);
    chk("R4 level held", 256'(rd_level), 256'd0);
    chk("R4 underflow set", 256'(rd_unf), 256'd1);
    rd_wait(3);
    chk("R4 underflow sticky", 256'(rd_unf), 256'd1);
  endtask

  task automatic t_fill;
    wr_wait(8);
    chk("R5 wr_level drained", 256'(wr_level), 256'd0);
    for (int i = 0; i < 2048; i++) begin
      @(negedge wr_clk);
      wr_en = 1; wr_data = mkw(wr_idx); wr_idx++;
    end
    @(negedge wr_clk);
    wr_en = 0;
    chk("R3 full", 256'(wr_full), 256'd1);
    chk("R5 wr_level max", 256'(wr_level), 256'd2048);
    chk("R3 no ovf yet", 256'(wr_ovf), 256'd0);
    @(negedge wr_clk); wr_en = 1; wr_data = '1;
    @(negedge wr_clk); wr_en = 0;
    chk("R3 ovf set", 256'(wr_ovf), 256'd1);
    chk("R3 level held", 256'(wr_level), 256'd2048);
    rd_wait(6);
    chk("R5 rd_level max", 256'(rd_level), 256'd1024);
    for (int i = 0; i < 1024; i++) pop_check("R3 dropped write absent");
    rd_wait(2);
    chk("R2 empty after drain", 256'(rd_empty), 256'd1);
    wr_wait(8);
    chk("R5 wr_level after drain", 256'(wr_level), 256'd0);
    chk("R3 ovf sticky", 256'(wr_ovf), 256'd1);
  endtask

  task automatic t_burst;
    int target;
    target = rd_idx + 512;
    fork
      begin
        for (int b = 0; b < 16; b++) begin
          for (int i = 0; i < 32; i++) begin
            @(negedge wr_clk);
            wr_en = 1; wr_data = mkw(wr_idx); wr_idx++;
          end
          @(negedge wr_clk); wr_en = 0;
          wr_wait(b % 3 * 7 + 5);
        end
      end
      begin
        while (rd_idx < target) begin
          @(negedge rd_clk);
          if (rd_en) begin
            chk("R7 burst order", rd_data, {mkw(rd_idx + 1), mkw(rd_idx)});
            rd_idx += 2;
          end
          rd_en = !rd_empty && (rd_idx < target);
        end
        rd_en = 0;
      end
    join
    rd_wait(6);
    chk("R7 empty at end", 256'(rd_empty), 256'd1);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge wr_clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      finish_run();
    end
  end

  initial begin
    #55 wr_rst_n = 1;
    #71 rd_rst_n = 1;
    t_reset();
    t_pairing();
    t_underflow();
    t_fill();
    t_burst();
    done = 1;
    finish_run();
  end
endmodule